// File: doc/BRIEF.md
# J1850 Receive State-Vector Controller

This block sits between a J1850 symbol decoder and a host CPU. The decoder reports three kinds of symbol-level events: a completed byte with its data, an end-of-data idle, and an end-of-frame idle. The block turns these into a small CPU-visible status model. That model consists of a data register, a prioritised state-vector code, an interrupt line and an overrun flag.

A byte that arrives before the first end-of-data idle of a frame is a normal message byte. Once that idle is seen, the frame enters its in-frame-response (IFR) phase. Every byte from then on is reported with a distinct IFR-byte code. The start of the IFR phase is not reported separately, because the IFR-byte code itself shows that the main message has ended.

A CRC-8 is accumulated over the IFR bytes. It is judged only when a further end-of-data idle follows the last IFR byte, and only if the IFR type input says a CRC byte is present. The CPU clears byte events by reading the data register and clears end-of-frame and CRC-error events with an acknowledge strobe. It can also freeze the state vector with an ignore bit.

Top module: `j1850_rx_sv`

## Requirements
- R1: After reset, `data_out` is 0, `state_code` is 0 (nothing pending), `irq` is 0, `overrun` is 0 and `ignore` is 0.
- R2: A byte event before the frame's first end-of-data idle loads `ev_data` into `data_out` and raises code 1 (message byte) with `irq` high.
- R3: A byte event after a frame's first end-of-data idle raises code 2 (IFR byte) and loads `data_out`. The end-of-data idle that starts the IFR phase changes no code and no `irq` by itself.
- R4: A `cpu_rd_data` pulse clears a pending message-byte or IFR-byte event. Each later IFR byte raises code 2 again.
- R5: Every IFR byte, the trailing CRC byte included, appears on `data_out` as it arrives.
- R6: With `ifr_has_crc`=1, an end-of-data idle after at least one IFR byte checks the CRC. The CRC is CRC-8 with polynomial 0x1D over the IFR bytes, initial value 0xFF; the transmitted CRC byte is the inverted register. A running register other than 0xC4 after the CRC byte raises code 4 (CRC error).
- R7: With `ifr_has_crc`=0 the CRC check is skipped, and no code 4 is raised whatever the IFR bytes are.
- R8: An end-of-frame event raises code 3 and ends the IFR phase, so the next byte is again a message byte (code 1).
- R9: With several events pending, `state_code` shows the highest: 4 over 3 over 2 over 1. `irq` stays high while any event is pending.
- R10: A `cpu_ack` pulse clears the end-of-frame or CRC-error event that `state_code` currently shows, exposing the next pending one.
- R11: A byte event while an earlier byte is still unread overwrites `data_out` and sets `overrun`. `overrun` stays set until `cpu_rd_data`.
- R12: While `ignore` is set (by `cpu_ign_set`, cleared by `cpu_ign_clr`), `state_code` and `irq` hold their value. Once it clears, they show the pending events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_byte | input | 1 | Decoder strobe: one byte received |
| ev_data | input | 8 | Byte value accompanying `ev_byte` |
| ev_eod | input | 1 | Decoder strobe: end-of-data idle seen |
| ev_eof | input | 1 | Decoder strobe: end-of-frame idle seen |
| ifr_has_crc | input | 1 | IFR type: 1 when the IFR ends with a CRC byte |
| cpu_rd_data | input | 1 | CPU read of the data register |
| cpu_ack | input | 1 | CPU acknowledge of a displayed end-of-frame or CRC-error code |
| cpu_ign_set | input | 1 | Set the ignore bit |
| cpu_ign_clr | input | 1 | Clear the ignore bit |
| data_out | output | 8 | Data register |
| state_code | output | 3 | State-vector code (0 none, 1 message byte, 2 IFR byte, 3 end of frame, 4 CRC error) |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Unread byte was overwritten |
| ignore | output | 1 | Ignore bit |

## Verification
IFR payloads of one to four bytes are sent with a correct CRC byte and then with the CRC byte corrupted in each of its eight bit positions. This separates a correct residue comparison from one that misses single-bit errors or checks at the wrong moment. The same corrupted frames are repeated with the CRC-type input off, which shows that the check is gated by that input. Overlaid event patterns (an unread message byte followed by an IFR byte, a CRC error followed by end of frame, a byte while ignoring) expose errors in the priority order, in the overrun flag and in the freeze.

// File: rtl/j1850_sv_pkg.sv
package j1850_sv_pkg;

   typedef enum logic [2:0] {
      SV_NONE = 3'd0,
      SV_RXB  = 3'd1,
      SV_IFR  = 3'd2,
      SV_EOF  = 3'd3,
      SV_CRC  = 3'd4
   } sv_code_e;

   typedef struct packed {
      logic crc;
      logic eof;
      logic ifr;
      logic rxb;
   } pend_t;

endpackage

// File: rtl/j1850_crc_acc.sv
module j1850_crc_acc #(
   parameter int unsigned W    = 8,
   parameter int unsigned POLY = 'h1D,
   parameter int unsigned SEED = 'hFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] din,
   output logic [W-1:0] crc_q
);
   localparam logic [W-1:0] POLY_V = W'(POLY);
   localparam logic [W-1:0] SEED_V = W'(SEED);

   logic [W-1:0] nxt;

   always_comb begin
      logic [W-1:0] c;
      logic fb;
      c = crc_q;
      for (int b = W - 1; b >= 0; b--) begin
         fb = c[W-1] ^ din[b];
         c  = {c[W-2:0], 1'b0};
         if (fb) c = c ^ POLY_V;
      end
      nxt = c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= '0;
      else if (load) crc_q <= SEED_V;
      else if (step) crc_q <= nxt;
   end

   a_r6_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> crc_q == SEED_V);

endmodule

// File: rtl/j1850_sv_pending.sv
module j1850_sv_pending
   import j1850_sv_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  byte_ev,
   input  logic  in_ifr,
   input  logic  rd_data,
   input  logic  crc_fail,
   input  logic  eof_ev,
   input  logic  ack_crc,
   input  logic  ack_eof,
   output pend_t pend_q,
   output logic  ovr_q
);
   logic byte_unread;
   assign byte_unread = pend_q.rxb | pend_q.ifr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (rd_data) begin
            pend_q.rxb <= 1'b0;
            pend_q.ifr <= 1'b0;
         end
         if (byte_ev) begin
            if (in_ifr) pend_q.ifr <= 1'b1;
            else        pend_q.rxb <= 1'b1;
         end
         if (ack_eof) pend_q.eof <= 1'b0;
         if (eof_ev)  pend_q.eof <= 1'b1;
         if (ack_crc)  pend_q.crc <= 1'b0;
         if (crc_fail) pend_q.crc <= 1'b1;
         if (rd_data) ovr_q <= 1'b0;
         if (byte_ev && byte_unread && !rd_data) ovr_q <= 1'b1;
      end
   end

   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !byte_ev) |=> !(pend_q.rxb || pend_q.ifr));

   a_r11_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ev && byte_unread && !rd_data) |=> ovr_q);

   a_r11_overrun_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !rd_data) |=> ovr_q);

endmodule

// File: rtl/j1850_sv_encode.sv
module j1850_sv_encode
   import j1850_sv_pkg::*;
(
   input  pend_t    pend,
   output sv_code_e code
);
   always_comb begin
      if (pend.crc)      code = SV_CRC;
      else if (pend.eof) code = SV_EOF;
      else if (pend.ifr) code = SV_IFR;
      else if (pend.rxb) code = SV_RXB;
      else               code = SV_NONE;
   end
endmodule

// File: rtl/j1850_rx_sv.sv
module j1850_rx_sv
   import j1850_sv_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CODE_W       = 3,
   parameter int unsigned CRC_POLY     = 'h1D,
   parameter int unsigned CRC_SEED     = 'hFF,
   parameter int unsigned CRC_RESIDUE  = 'hC4,
   parameter bit          CRC_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_byte,
   input  logic [DATA_W-1:0] ev_data,
   input  logic              ev_eod,
   input  logic              ev_eof,
   input  logic              ifr_has_crc,
   input  logic              cpu_rd_data,
   input  logic              cpu_ack,
   input  logic              cpu_ign_set,
   input  logic              cpu_ign_clr,
   output logic [DATA_W-1:0] data_out,
   output logic [CODE_W-1:0] state_code,
   output logic              irq,
   output logic              overrun,
   output logic              ignore
);
   localparam logic [DATA_W-1:0] RESIDUE_V = DATA_W'(CRC_RESIDUE);

   generate
      if (CODE_W < 3) begin : g_bad_code_w
         $error("CODE_W must hold five state codes");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W too small for a CRC register");
      end
   endgenerate

   logic        ifr_phase_q;
   logic        ifr_seen_q;
   logic        ign_q;
   sv_code_e    sv_q;
   sv_code_e    sv_next;
   pend_t       pend;
   logic        ovr;
   logic        enter_ifr;
   logic        check_now;
   logic        crc_fail;
   logic        ifr_byte;

   assign enter_ifr = ev_eod && !ifr_phase_q;
   assign check_now = ev_eod && ifr_phase_q && ifr_seen_q;
   assign ifr_byte  = ev_byte && ifr_phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ifr_phase_q <= 1'b0;
         ifr_seen_q  <= 1'b0;
      end else if (ev_eof) begin
         ifr_phase_q <= 1'b0;
         ifr_seen_q  <= 1'b0;
      end else begin
         if (enter_ifr) ifr_phase_q <= 1'b1;
         if (ifr_byte)  ifr_seen_q  <= 1'b1;
         else if (check_now) ifr_seen_q <= 1'b0;
      end
   end

   generate
      if (CRC_CHECK_EN) begin : g_crc
         logic [DATA_W-1:0] crc_q;
         j1850_crc_acc #(
            .W   (DATA_W),
            .POLY(CRC_POLY),
            .SEED(CRC_SEED)
         ) u_crc (
            .clk  (clk),
            .rst_n(rst_n),
            .load (enter_ifr),
            .step (ifr_byte),
            .din  (ev_data),
            .crc_q(crc_q)
         );
         assign crc_fail = check_now && ifr_has_crc && (crc_q != RESIDUE_V);
      end else begin : g_no_crc
         assign crc_fail = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          data_out <= '0;
      else if (ev_byte)    data_out <= ev_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ign_q <= 1'b0;
      else if (cpu_ign_clr) ign_q <= 1'b0;
      else if (cpu_ign_set) ign_q <= 1'b1;
   end

   j1850_sv_pending u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_ev (ev_byte),
      .in_ifr  (ifr_phase_q),
      .rd_data (cpu_rd_data),
      .crc_fail(crc_fail),
      .eof_ev  (ev_eof),
      .ack_crc (cpu_ack && sv_q == SV_CRC),
      .ack_eof (cpu_ack && sv_q == SV_EOF),
      .pend_q  (pend),
      .ovr_q   (ovr)
   );

   j1850_sv_encode u_enc (
      .pend(pend),
      .code(sv_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sv_q <= SV_NONE;
      else if (!ign_q) sv_q <= sv_next;
   end

   assign state_code = CODE_W'(sv_q);
   assign irq        = (sv_q != SV_NONE);
   assign overrun    = ovr;
   assign ignore     = ign_q;

   a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte |=> data_out == $past(ev_data));

   a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ign_q |=> $stable(sv_q));

   a_r9_crc_top: assert property (@(posedge clk) disable iff (!rst_n)
      (pend.crc && !ign_q) |=> sv_q == SV_CRC);

   a_r9_eof_over_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      (pend.eof && !pend.crc && !ign_q) |=> sv_q == SV_EOF);

   a_r8_eof_ends_ifr: assert property (@(posedge clk) disable iff (!rst_n)
      ev_eof |=> !ifr_phase_q);

   a_r7_no_crc_type: assert property (@(posedge clk) disable iff (!rst_n)
      (check_now && !ifr_has_crc && !pend.crc) |=> !pend.crc);

endmodule

// File: tb/tb_j1850_rx_sv.sv
module tb_j1850_rx_sv;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_byte = 0, ev_eod = 0, ev_eof = 0, ifr_has_crc = 0;
   logic [7:0] ev_data = 0;
   logic       cpu_rd_data = 0, cpu_ack = 0, cpu_ign_set = 0, cpu_ign_clr = 0;
   logic [7:0] data_out;
   logic [2:0] state_code;
   logic       irq, overrun, ignore;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   j1850_rx_sv dut (
      .clk(clk), .rst_n(rst_n), .ev_byte(ev_byte), .ev_data(ev_data),
      .ev_eod(ev_eod), .ev_eof(ev_eof), .ifr_has_crc(ifr_has_crc),
      .cpu_rd_data(cpu_rd_data), .cpu_ack(cpu_ack),
      .cpu_ign_set(cpu_ign_set), .cpu_ign_clr(cpu_ign_clr),
      .data_out(data_out), .state_code(state_code), .irq(irq),
      .overrun(overrun), .ignore(ignore)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[7] ^ d[i]) r = (r << 1) ^ 8'h1D;
         else             r = r << 1;
      end
      return r;
   endfunction

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic put_byte(input logic [7:0] d);
      @(negedge clk); ev_byte = 1; ev_data = d;
      @(negedge clk); ev_byte = 0;
      settle();
   endtask

   task automatic put_eod();
      @(negedge clk); ev_eod = 1;
      @(negedge clk); ev_eod = 0;
      settle();
   endtask

   task automatic put_eof();
      @(negedge clk); ev_eof = 1;
      @(negedge clk); ev_eof = 0;
      settle();
   endtask

   task automatic rd();
      @(negedge clk); cpu_rd_data = 1;
      @(negedge clk); cpu_rd_data = 0;
      settle();
   endtask

   task automatic ack();
      @(negedge clk); cpu_ack = 1;
      @(negedge clk); cpu_ack = 0;
      settle();
   endtask

   task automatic frame(input int n, input int seed, input bit has_crc, input logic [7:0] flip);
      logic [7:0] c;
      logic [7:0] b;
      logic [7:0] crc_byte;
      bit bad;
      ifr_has_crc = has_crc;
      put_byte(8'h6A ^ 8'(seed));
      check("R2 msg code", state_code, 1);
      rd();
      check("R4 msg read clears", state_code, 0);
      put_eod();
      check("R3 eod silent", {irq, state_code}, 0);
      c = 8'hFF;
      for (int k = 0; k < n; k++) begin
         b = 8'(seed * 37 + k * 91 + 5);
         c = crc_step(c, b);
         put_byte(b);
         check("R3 ifr code", state_code, 2);
         check("R5 ifr data", data_out, b);
         rd();
         check("R4 ifr read clears", state_code, 0);
      end
      crc_byte = ~c ^ flip;
      put_byte(crc_byte);
      check("R5 crc byte data", data_out, crc_byte);
      rd();
      put_eod();
      bad = has_crc && (flip != 0);
      check(has_crc ? "R6 crc verdict" : "R7 crc skipped", state_code, bad ? 4 : 0);
      put_eof();
      check("R9 crc over eof", state_code, bad ? 4 : 3);
      if (bad) begin
         ack();
         check("R10 ack crc shows eof", state_code, 3);
      end
      ack();
      check("R10 ack eof", {irq, state_code}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 data", data_out, 0);
      check("R1 code", state_code, 0);
      check("R1 irq", irq, 0);
      check("R1 ovr", overrun, 0);
      check("R1 ign", ignore, 0);
      rst_n = 1;
      settle();

      for (int n = 1; n <= 4; n++) begin
         frame(n, n, 1'b1, 8'h00);
         for (int bit_i = 0; bit_i < 8; bit_i++) begin
            frame(n, n + bit_i, 1'b1, 8'(1 << bit_i));
            frame(n, n + bit_i, 1'b0, 8'(1 << bit_i));
         end
      end

      // R8: after EOF a byte is a message byte again
      put_byte(8'h11);
      check("R8 back to msg", state_code, 1);
      // R9/R11: unread message byte then IFR byte
      put_eod();
      put_byte(8'h22);
      check("R9 ifr over msg", state_code, 2);
      check("R11 overrun", overrun, 1);
      check("R11 overwrite", data_out, 8'h22);
      put_eof();
      check("R9 eof over ifr", state_code, 3);
      check("R9 irq", irq, 1);
      ack();
      check("R10 ack exposes ifr", state_code, 2);
      rd();
      check("R11 read clears ovr", overrun, 0);
      check("R4 read clears all", state_code, 0);

      // R12: ignore freezes state vector
      @(negedge clk); cpu_ign_set = 1;
      @(negedge clk); cpu_ign_set = 0;
      settle();
      check("R12 ign set", ignore, 1);
      put_byte(8'h33);
      check("R12 frozen code", state_code, 0);
      check("R12 frozen irq", irq, 0);
      check("R12 data still loads", data_out, 8'h33);
      @(negedge clk); cpu_ign_clr = 1;
      @(negedge clk); cpu_ign_clr = 0;
      settle();
      check("R12 resumes", state_code, 1);
      rd();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule